// File: doc/BRIEF.md
# Address-Stability Sleep Detector

This block sits beside a parallel memory array and tracks how long the address bus has held one value. While the address keeps changing, the array stays enabled and each new read result is caught in an output register once the access time has run out. When the address has stayed the same for the access time plus a fixed settling margin, and the read result for that address is held, the block raises a sleep flag and drops the array-enable strobe. The held data stays on the output for as long as the sleep lasts.

The chip-enable, write-enable and output-enable controls have no say in this decision, and the block has no inputs for them. Only the address decides. Any new address wakes the array in the same cycle that the change is seen. The new data then follows with the normal access latency. The margin is given in nanoseconds and is turned into clock cycles from the clock period when the design is elaborated.

Top module: `addr_idle_sleep`

## Requirements
- R1: After reset, and while reset is held, `sleep_o` is 0, `arr_en_o` is 1 and `rd_q_o` is all zeros.
- R2: Clock edge E0 is the first edge that sees a new address. If `rd_q_o` already holds that address's data, `sleep_o` is first high after edge E(SLEEP_CYC), where SLEEP_CYC = ACC_CYC + ceil(MARGIN_NS*1000/CLK_PS). Before that edge it is low.
- R3: In any cycle where `addr_i` differs from the address seen at the previous edge, `sleep_o` is 0 and `arr_en_o` is 1, with no delay.
- R4: `arr_en_o` is always the complement of `sleep_o`.
- R5: The stability count returns to zero on every address change and stops at SLEEP_CYC.
- R6: With `rd_ready_i` high, `rd_q_o` takes `rd_data_i` at edge E(ACC_CYC+1). If `rd_ready_i` is low then, the capture moves to the first later edge where it is high, as long as the address has not changed. Each address is captured only once.
- R7: While `sleep_o` is high, `rd_q_o` does not change.
- R8: Driving the same address value again is not a change. Counting and sleep carry on as before.
- R9: If the address changes before the capture edge, `rd_q_o` keeps the previously latched value.
- R10: After a wake-up from sleep, the new address is captured and sleep is re-entered on the same schedule as in R2 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Address bus being watched |
| rd_data_i | input | DATA_W | Read data from the array |
| rd_ready_i | input | 1 | Array read data is valid |
| rd_q_o | output | DATA_W | Latched read data |
| sleep_o | output | 1 | Array is in sleep |
| arr_en_o | output | 1 | Array enable strobe |

## Verification
Each address the driver presents is treated as time zero. The wake-up (R3) is due in that same cycle. The latched data is due ACC_CYC+2 cycles later, or one cycle after the first ready cycle, whichever is later. Sleep is due SLEEP_CYC+1 cycles later, or the cycle after capture, whichever is later. For every cycle of every hold window the driver queues the expected data, sleep flag and enable, each tagged with its exact cycle number. The monitor samples on the falling edge and compares only items whose cycle number matches the current one. This keeps every comparison aligned to the register count of each path.

// File: rtl/aisd_pkg.sv
package aisd_pkg;

   // Whole clock cycles that cover a delay in ns, rounded up
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
      return (ns * 1000 + clk_ps - 1) / clk_ps;
   endfunction

   typedef struct packed {
      logic acc_done;  // count has passed the access time
      logic full;      // count has reached the sleep threshold
   } stab_flags_t;

endpackage

// File: rtl/aisd_chg_det.sv
module aisd_chg_det #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned LANE_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              chg_o
);
   localparam int unsigned NLANE = (ADDR_W + LANE_W - 1) / LANE_W;
   localparam int unsigned PAD_W = NLANE * LANE_W;

   if (LANE_W < 1 || LANE_W > ADDR_W) begin : g_bad_lane
      $error("aisd_chg_det: LANE_W must lie in 1..ADDR_W");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [PAD_W-1:0]  cur_p;
   logic [PAD_W-1:0]  old_p;
   logic [NLANE-1:0]  lane_diff;

   always_ff @(posedge clk_i) begin
      if (rst_i) addr_q <= '0;
      else       addr_q <= addr_i;
   end

   assign cur_p = PAD_W'(addr_i);
   assign old_p = PAD_W'(addr_q);

   // Compare lane by lane, then OR-reduce, to keep the compare tree shallow
   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      assign lane_diff[g] = cur_p[g*LANE_W +: LANE_W] != old_p[g*LANE_W +: LANE_W];
   end

   assign chg_o = |lane_diff;

endmodule

// File: rtl/aisd_stab_cnt.sv
module aisd_stab_cnt
   import aisd_pkg::*;
#(
   parameter int unsigned ACC_CYC   = 18,
   parameter int unsigned SLEEP_CYC = 26
) (
   input  logic        clk_i,
   input  logic        rst_i,
   input  logic        chg_i,
   output stab_flags_t flags_o
);
   localparam int unsigned CW = $clog2(SLEEP_CYC + 1);
   localparam logic [CW-1:0] ACC_V   = CW'(ACC_CYC);
   localparam logic [CW-1:0] SLEEP_V = CW'(SLEEP_CYC);

   if (ACC_CYC >= SLEEP_CYC) begin : g_bad_thr
      $error("aisd_stab_cnt: SLEEP_CYC must exceed ACC_CYC");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)                cnt_q <= '0;
      else if (chg_i)           cnt_q <= '0;
      else if (cnt_q != SLEEP_V) cnt_q <= cnt_q + 1'b1;
   end

   assign flags_o.acc_done = cnt_q >= ACC_V;
   assign flags_o.full     = cnt_q == SLEEP_V;

   // R5: the count never goes past the threshold
   a_r5_cnt_sat: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= SLEEP_V);

   // R5: an address change restarts the count
   a_r5_cnt_clear: assert property (@(posedge clk_i) disable iff (rst_i)
      chg_i |=> cnt_q == '0);

endmodule

// File: rtl/aisd_data_hold.sv
module aisd_data_hold
   import aisd_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              chg_i,
   input  stab_flags_t       flags_i,
   input  logic              rdy_i,
   input  logic [DATA_W-1:0] rd_i,
   output logic              got_o,
   output logic [DATA_W-1:0] dat_o
);
   logic              got_q;
   logic [DATA_W-1:0] dat_q;
   logic              cap;

   assign cap = !chg_i && flags_i.acc_done && !got_q && rdy_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         got_q <= 1'b0;
         dat_q <= '0;
      end else if (chg_i) begin
         got_q <= 1'b0;
      end else if (cap) begin
         got_q <= 1'b1;
         dat_q <= rd_i;
      end
   end

   assign got_o = got_q;
   assign dat_o = dat_q;

   // R6: nothing is captured before the access time has run out
   a_r6_no_early_cap: assert property (@(posedge clk_i) disable iff (rst_i)
      !flags_i.acc_done |=> $stable(dat_o));

endmodule

// File: rtl/addr_idle_sleep.sv
module addr_idle_sleep
   import aisd_pkg::*;
#(
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned LANE_W    = 4,
   parameter int unsigned ACC_CYC   = 18,
   parameter int unsigned MARGIN_NS = 30,
   parameter int unsigned CLK_PS    = 4000
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              rd_ready_i,
   output logic [DATA_W-1:0] rd_q_o,
   output logic              sleep_o,
   output logic              arr_en_o
);
   localparam int unsigned MARGIN_CYC = ns_to_cyc(MARGIN_NS, CLK_PS);
   localparam int unsigned SLEEP_CYC  = ACC_CYC + MARGIN_CYC;

   if (ACC_CYC < 1 || MARGIN_CYC < 1) begin : g_bad_timing
      $error("addr_idle_sleep: access time and margin need at least one cycle each");
   end
   if (DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("addr_idle_sleep: widths must be non-zero");
   end

   logic        chg;
   logic        got;
   stab_flags_t flags;

   aisd_chg_det #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chg (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .addr_i(addr_i),
      .chg_o (chg)
   );

   aisd_stab_cnt #(.ACC_CYC(ACC_CYC), .SLEEP_CYC(SLEEP_CYC)) u_cnt (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .chg_i  (chg),
      .flags_o(flags)
   );

   aisd_data_hold #(.DATA_W(DATA_W)) u_hold (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .chg_i  (chg),
      .flags_i(flags),
      .rdy_i  (rd_ready_i),
      .rd_i   (rd_data_i),
      .got_o  (got),
      .dat_o  (rd_q_o)
   );

   assign sleep_o  = flags.full && got && !chg;
   assign arr_en_o = !sleep_o;

   // R7: the latched data holds still through sleep
   a_r7_hold_asleep: assert property (@(posedge clk_i) disable iff (rst_i)
      sleep_o |=> $stable(rd_q_o));

   // R3: a seen address change wakes the array at once
   a_r3_wake_now: assert property (@(posedge clk_i) disable iff (rst_i)
      chg |-> (arr_en_o && !sleep_o));

endmodule

// File: tb/addr_idle_sleep_tb.sv
module addr_idle_sleep_tb_top;
   localparam int ACC    = 18;
   localparam int MARGIN = (30 * 1000 + 4000 - 1) / 4000;
   localparam int SLEEP  = ACC + MARGIN;

   typedef struct packed {
      int          cyc;
      logic [15:0] d;
      logic        s;
      logic        e;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [19:0] addr = '0;
   logic        rdy = 1'b1;
   logic [15:0] rd_data;
   logic [15:0] rd_q;
   logic        sleep;
   logic        arr_en;

   int   cyc = 0;
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   exp_t  exp_q[$];
   string tag_q[$];

   // Driver model state
   logic [19:0] cur_a = '0;
   bit          fresh = 1'b1;
   int          kk = 0;
   bit          capd = 1'b0;
   logic [15:0] latched = '0;

   always #2 clk = ~clk;   // 250 MHz
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [15:0] data_of(input logic [19:0] a);
      return 16'(a[15:0] * 16'h9E37) ^ {12'h0, a[19:16]} ^ 16'h5A5A;
   endfunction

   assign rd_data = data_of(addr);

   addr_idle_sleep dut_i (
      .clk_i     (clk),
      .rst_i     (rst),
      .addr_i    (addr),
      .rd_data_i (rd_data),
      .rd_ready_i(rdy),
      .rd_q_o    (rd_q),
      .sleep_o   (sleep),
      .arr_en_o  (arr_en)
   );

   task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s at cycle %0d: got %h, want %h", tag, what, cyc, act, exp);
      end
   endtask

   // Present address a for hold cycles; rd_ready_i stays low for the first rl cycles
   task automatic access(input logic [19:0] a, input int hold, input int rl, input string tag);
      bit es;
      @(posedge clk); #1;
      if (fresh || a != cur_a) begin
         kk = 0;
         capd = 1'b0;
      end
      fresh = 1'b0;
      addr = a;
      cur_a = a;
      for (int i = 0; i < hold; i++) begin
         if (i > 0) begin
            @(posedge clk); #1;
         end
         rdy = (i >= rl);
         es = (kk >= SLEEP + 1) && capd;
         exp_q.push_back('{cyc: cyc, d: latched, s: es, e: !es});
         tag_q.push_back(tag);
         if (!capd && kk >= ACC + 1 && rdy) begin
            capd = 1'b1;
            latched = data_of(a);
         end
         kk++;
      end
   endtask

   // Monitor: compare queued expectations in their own cycle
   always @(negedge clk) begin
      while (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
         exp_t  it;
         string tg;
         it = exp_q.pop_front();
         tg = tag_q.pop_front();
         chk(tg, "rd_q_o", rd_q, it.d);
         chk(tg, "sleep_o", {15'h0, sleep}, {15'h0, it.s});
         chk(tg, "arr_en_o R4", {15'h0, arr_en}, {15'h0, it.e});
      end
   end

   task automatic reset_checks();
      @(negedge clk);
      chk("R1", "sleep_o", {15'h0, sleep}, 16'h0);
      chk("R1", "arr_en_o", {15'h0, arr_en}, 16'h1);
      chk("R1", "rd_q_o", rd_q, 16'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      reset_checks();
      @(posedge clk); #1 rst = 1'b0;

      access(20'h00123, 40, 0, "R2 R6");          // capture, then sleep
      access(20'h00123, 10, 0, "R8 R7");          // same value again keeps sleeping
      access(20'h45678, 5, 0, "R3 R9");           // wake, leave before capture
      access(20'h0ABCD, 40, 0, "R10 R6");         // normal timing after a wake
      access(20'h11111, 40, 0, "R3 R10 R5");      // wake from sleep, count again
      access(20'h22222, 50, 30, "R6 R2");         // ready late: capture and sleep delayed
      access(20'h33333, SLEEP + 2, 0, "R2 R5");   // exact threshold edge

      @(posedge clk); #1 rst = 1'b1; addr = '0;
      @(posedge clk);
      reset_checks();
      @(posedge clk); #1 rst = 1'b0;
      fresh = 1'b1; latched = '0; capd = 1'b0;

      access(20'h44444, 40, 0, "R1 R6");          // clean start after a mid-run reset
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run hung at cycle %0d, want completion", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule